// File: doc/BRIEF.md
# Straight and Twisted Ring Counter

This block is a small counter built around a universal shift register of four stages. A two-bit operation code picks one of four actions on each enabled clock: keep the contents, move every bit one stage up (from Q0 toward Q3), move every bit one stage down (from Q3 toward Q0), or take a new pattern from the parallel data input. During an upward move the bit that enters Q0 comes from a feedback path. A single configuration input selects that feedback.

With plain feedback, Q3 returns to Q0 and a single seeded one circulates as a one-hot ring of four states. With inverted feedback, the complement of Q3 enters Q0, and a register seeded with all zeros walks through the eight states of a Johnson sequence. The seed is written with the load operation. An active-low clear empties the register at once. A clock enable freezes the register in every mode. A downward move takes its incoming top bit from a separate serial input.

The clear takes effect asynchronously. Its release is synchronized to the clock through two flops, so the register responds again only from the third rising edge after the clear input goes high.

Top module: `ring_twist_counter`

## Requirements
- R1: While clear_n is low, q reads 0000 without waiting for a clock edge, whatever the operation code or enable.
- R2: After clear_n rises, the first two rising edges leave q at 0000. The third edge is the first one that acts on q.
- R3: When step_en is low, q keeps its value at the rising edge for every operation code and either feedback setting.
- R4: Operation code 2'b00 (hold) keeps q unchanged.
- R5: Operation code 2'b11 (load) copies seed[i] into q[i] at the rising edge, for each i from 0 to 3. The twisted input has no effect.
- R6: Operation code 2'b01 (up move) with twisted low sets q[i+1] to the old q[i] and q[0] to the old q[3]. From the seed Q0..Q3 = 1000 (q = 4'b0001), the register visits 1000, 0100, 0010, 0001 and then returns to 1000. This is a cycle of 4 states.
- R7: Operation code 2'b01 with twisted high moves the same way, but q[0] takes the complement of the old q[3]. From 0000 the register visits 0000, 1000, 1100, 1110, 1111, 0111, 0011, 0001 (Q0..Q3) and then returns to 0000. This is a cycle of 8 states.
- R8: Operation code 2'b10 (down move) sets q[i] to the old q[i+1] and q[3] to ser_down. The twisted input has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge system clock |
| clear_n | input | 1 | Active-low clear. Takes effect asynchronously; its release is synchronized |
| step_en | input | 1 | Synchronous clock enable |
| op | input | 2 | Operation code: 00 hold, 01 up move, 10 down move, 11 load |
| twisted | input | 1 | Feedback select: 0 feeds back Q3, 1 feeds back the complement of Q3 |
| seed | input | 4 | Parallel data taken by the load operation (bit i goes to Q i) |
| ser_down | input | 1 | Bit that enters Q3 during a down move |
| q | output | 4 | Register stages Q0..Q3 (bit i is Q i) |

## Verification
The properties that check the register's response to each edge assume two things about the inputs. First, op, twisted, seed, ser_down and step_en hold steady around every rising edge. Second, clear_n changes only well away from an edge. The bench meets both conditions by changing every input on the falling clock edge, including the assertion and release of the clear.

The properties also treat an edge as active only when the synchronized release was already high before that edge. This matches the two-edge delay that the bench checks directly at the ports. The sweep seeds the register with all sixteen patterns and, for each one, applies every combination of operation code, feedback select, serial input and enable.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef enum logic [1:0] {
    OP_HOLD = 2'b00,
    OP_UP   = 2'b01,
    OP_DOWN = 2'b10,
    OP_LOAD = 2'b11
  } rtc_op_e;

endpackage

// File: rtl/rtc_reset_sync.sv
module rtc_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_r;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_r <= '0;
    else         chain_r <= {chain_r[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_r[STAGES-1];

endmodule

// File: rtl/rtc_feedback.sv
module rtc_feedback (
  input  logic last_stage,
  input  logic invert,
  output logic fb_bit
);

  always_comb begin
    fb_bit = last_stage ^ invert;
  end

endmodule

// File: rtl/rtc_next_state.sv
module rtc_next_state
  import rtc_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] cur,
  input  logic [1:0]       op,
  input  logic             fb_bit,
  input  logic             ser_down,
  input  logic [WIDTH-1:0] seed,
  output logic [WIDTH-1:0] nxt
);

  logic [WIDTH-1:0] from_below;
  logic [WIDTH-1:0] from_above;
  rtc_op_e          op_e;

  assign op_e = rtc_op_e'(op);

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    if (i == 0) begin : g_first
      assign from_below[i] = fb_bit;
    end else begin : g_mid_lo
      assign from_below[i] = cur[i-1];
    end
    if (i == WIDTH-1) begin : g_last
      assign from_above[i] = ser_down;
    end else begin : g_mid_hi
      assign from_above[i] = cur[i+1];
    end

    always_comb begin
      unique case (op_e)
        OP_HOLD: nxt[i] = cur[i];
        OP_UP:   nxt[i] = from_below[i];
        OP_DOWN: nxt[i] = from_above[i];
        OP_LOAD: nxt[i] = seed[i];
        default: nxt[i] = cur[i];
      endcase
    end
  end

endmodule

// File: rtl/ring_twist_counter.sv
module ring_twist_counter #(
  parameter int WIDTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             clear_n,
  input  logic             step_en,
  input  logic [1:0]       op,
  input  logic             twisted,
  input  logic [WIDTH-1:0] seed,
  input  logic             ser_down,
  output logic [WIDTH-1:0] q
);

  localparam int TOP = WIDTH - 1;

  logic             rst_s_n;
  logic             fb_bit;
  logic [WIDTH-1:0] q_r;
  logic [WIDTH-1:0] q_nxt;

  rtc_reset_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (clear_n),
    .srst_n (rst_s_n)
  );

  rtc_feedback u_fb (
    .last_stage (q_r[TOP]),
    .invert     (twisted),
    .fb_bit     (fb_bit)
  );

  rtc_next_state #(.WIDTH(WIDTH)) u_nxt (
    .cur      (q_r),
    .op       (op),
    .fb_bit   (fb_bit),
    .ser_down (ser_down),
    .seed     (seed),
    .nxt      (q_nxt)
  );

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)     q_r <= '0;
    else if (step_en) q_r <= q_nxt;
  end

  assign q = q_r;

  // R1
  clear_zero_chk: assert property (@(posedge clk) !clear_n |-> q == '0);

  // R3
  enable_hold_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (rst_s_n && !step_en) |=> q == $past(q));

  // R4
  op_hold_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (rst_s_n && step_en && op == 2'b00) |=> q == $past(q));

  // R5
  load_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (rst_s_n && step_en && op == 2'b11) |=> q == $past(seed));

  // R6
  ring_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (rst_s_n && step_en && op == 2'b01 && !twisted)
      |=> q == {$past(q[TOP-1:0]), $past(q[TOP])});

  // R6
  ring_ones_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (rst_s_n && step_en && op == 2'b01 && !twisted)
      |=> $countones(q) == $countones($past(q)));

  // R7
  twist_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (rst_s_n && step_en && op == 2'b01 && twisted)
      |=> (q[0] != $past(q[TOP])) && (q[TOP:1] == $past(q[TOP-1:0])));

  // R8
  down_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (rst_s_n && step_en && op == 2'b10)
      |=> q == {$past(ser_down), $past(q[TOP:1])});

endmodule

// File: tb/ring_twist_counter_test.sv
module ring_twist_counter_test;

  logic       clk = 1'b0;
  logic       clear_n;
  logic       step_en;
  logic [1:0] op;
  logic       twisted;
  logic [3:0] seed;
  logic       ser_down;
  logic [3:0] q;

  int n_vec = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  ring_twist_counter uut (
    .clk(clk), .clear_n(clear_n), .step_en(step_en), .op(op),
    .twisted(twisted), .seed(seed), .ser_down(ser_down), .q(q)
  );

  task automatic check(input string tag, input logic [3:0] exp);
    n_vec++;
    if (q !== exp) begin
      n_bad++;
      $display("FAIL %s: q=%b expected %b", tag, q, exp);
    end
  endtask

  // Drive inputs at the falling edge, pass one rising edge, sample 1 ns later.
  task automatic cycle(input logic en, input logic [1:0] o, input logic tw,
                       input logic [3:0] sd, input logic sl);
    @(negedge clk);
    step_en = en; op = o; twisted = tw; seed = sd; ser_down = sl;
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog: q=%b expected run to end", q);
    finish_run();
  end

  initial begin
    clear_n = 1'b1; step_en = 1'b0; op = 2'b00; twisted = 1'b0;
    seed = 4'h0; ser_down = 1'b0;
    #1 clear_n = 1'b0;
    #0.5 check("R1 clear at start", 4'b0000);
    cycle(1'b1, 2'b11, 1'b0, 4'hF, 1'b1);
    check("R1 clear ignores clock and load", 4'b0000);

    // Release the clear: two ignored edges, then the first load takes effect.
    @(negedge clk);
    clear_n = 1'b1; step_en = 1'b1; op = 2'b11; seed = 4'b0101;
    @(posedge clk); #1 check("R2 first edge after release", 4'b0000);
    @(posedge clk); #1 check("R2 second edge after release", 4'b0000);
    @(posedge clk); #1 check("R2 third edge loads", 4'b0101);

    // Clear in the middle of a cycle, away from any edge.
    @(negedge clk);
    clear_n = 1'b0;
    #0.5 check("R1 asynchronous clear", 4'b0000);
    @(negedge clk);
    clear_n = 1'b1; step_en = 1'b0;
    repeat (3) @(posedge clk);
    #1;

    // Straight ring: Q0..Q3 = 1000 is q = 4'b0001.
    cycle(1'b1, 2'b11, 1'b0, 4'b0001, 1'b0);
    check("R5 ring seed", 4'b0001);
    for (int k = 1; k <= 8; k++) begin
      cycle(1'b1, 2'b01, 1'b0, 4'h0, 1'b0);
      check("R6 ring step", 4'(1 << (k % 4)));
    end

    // Twisted ring from 0000: eight states.
    cycle(1'b1, 2'b11, 1'b1, 4'b0000, 1'b1);
    check("R5 twisted seed", 4'b0000);
    for (int k = 1; k <= 16; k++) begin
      int p;
      logic [3:0] e;
      cycle(1'b1, 2'b01, 1'b1, 4'h0, 1'b1);
      p = k % 8;
      if (p <= 4) e = 4'((1 << p) - 1);
      else        e = 4'hF & ~4'((1 << (p - 4)) - 1);
      check("R7 twisted step", e);
    end

    // Sweep every seed against every operation and setting.
    for (int s = 0; s < 16; s++) begin
      for (int m = 0; m < 4; m++) begin
        for (int tw = 0; tw < 2; tw++) begin
          for (int sl = 0; sl < 2; sl++) begin
            for (int en = 0; en < 2; en++) begin
              logic [3:0] sv, e;
              string tag;
              sv = 4'(s);
              cycle(1'b1, 2'b11, 1'(tw), sv, 1'(sl));
              check("R5 sweep load", sv);
              if (en == 0) begin
                e = sv; tag = "R3 enable low";
              end else if (m == 0) begin
                e = sv; tag = "R4 hold";
              end else if (m == 1) begin
                e = {sv[2:0], sv[3] ^ 1'(tw)};
                tag = (tw != 0) ? "R7 twisted move" : "R6 ring move";
              end else if (m == 2) begin
                e = {1'(sl), sv[3:1]}; tag = "R8 down move";
              end else begin
                e = ~sv; tag = "R5 load";
              end
              cycle(1'(en), 2'(m), 1'(tw), ~sv, 1'(sl));
              check(tag, e);
            end
          end
        end
      end
    end

    finish_run();
  end

endmodule